// File: doc/BRIEF.md
# Output Driver Fault Supervisor

This block watches over a bank of output channels that sink load current, plus one shared supply and temperature monitor. Each channel has an overcurrent comparator bit. When a channel's overcurrent condition lasts long enough, the block latches that channel off. A latched channel stays off until the enable/reset input makes a low-to-high transition or the block is power-on reset. Overcurrent pulses that are too short to count are ignored.

Two chip-wide conditions force every channel off: thermal shutdown and supply undervoltage lockout. Thermal shutdown is driven by a digital die-temperature code. It does not latch, and the outputs come back on their own once the die has cooled below the trip point minus a hysteresis margin. Undervoltage lockout is driven by a digital logic-supply code, in units of 0.1 V. It uses separate release and lockout thresholds. All thresholds and the glitch filter length are parameters, and all time is counted in system clock cycles.

The per-channel inhibit bits go to the output register. A status vector shows which channels are currently latched off.

Top module: `fault_guard`

## Requirements
- R1: After power-on reset (rstN low), no channel is latched (faultVec = 0). The supply lockout is active, so globalOff = 1 and every chanOff bit is 1 until a valid supply code has been sampled on a clock edge.
- R2: Channel i latches off only when ocFlag[i] is sampled high on FILT_CYC consecutive rising clock edges. From the next cycle, faultVec[i] and chanOff[i] read 1. A run of FILT_CYC-1 or fewer high samples never latches the channel.
- R3: When ocFlag[i] drops before the count completes, the persistence count for that channel restarts from zero.
- R4: A latched channel stays latched after its ocFlag returns low. Each channel latches independently of the others.
- R5: A clock edge that samples enReset high, after it was low on the previous edge, clears every latched channel. Holding enReset high does not keep clearing, so an overcurrent that is still present re-latches after FILT_CYC more high samples.
- R6: When tempCode is sampled above TRIP_T, globalOff is 1 from the next cycle. This thermal state is not latched.
- R7: Once in thermal shutdown, the block leaves it on the first edge that samples tempCode below TRIP_T-HYST_T. Codes from TRIP_T-HYST_T up to TRIP_T keep the previous thermal state.
- R8: Lockout engages on an edge that samples vddCode below UV_OFF. It releases on an edge that samples vddCode at or above UV_ON. Codes between the two keep the previous state.
- R9: globalOff is 1 whenever thermal shutdown or lockout is active. chanOff[i] is faultVec[i] OR globalOff. A global shutdown neither sets nor clears channel latches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-on reset |
| ocFlag | input | NCH | Per-channel overcurrent comparator bits |
| tempCode | input | TEMP_W | Die temperature code, in degrees |
| vddCode | input | VDD_W | Logic supply code, in units of 0.1 V |
| enReset | input | 1 | Enable/reset input; a rising edge clears latched faults |
| chanOff | output | NCH | Per-channel inhibit to the output register |
| globalOff | output | 1 | Chip-wide shutdown (thermal or lockout) |
| faultVec | output | NCH | Channels currently latched off by overcurrent |

## Verification
The bench sweeps every channel with overcurrent runs from one to FILT_CYC+1 cycles long. A filter that is off by one either latches on a run one cycle short of the limit or needs one cycle too many. Broken overcurrent runs expose a counter that holds its count instead of restarting, since such a counter would latch on the combined length of the runs. Holding enReset high while the overcurrent persists catches a clear that acts on the level rather than the edge, because such a design would never re-latch the channel. Slow sweeps of the temperature and supply codes through both thresholds in each direction show whether a design has lost its hysteresis or compares at the wrong boundary. A design that latched thermal shutdown, or cleared channel latches during a global shutdown, would show the wrong chanOff pattern after recovery.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;

  // Strobes and state the control side hands to the datapath each cycle.
  typedef struct packed {
    logic clearAll;   // one-cycle pulse: drop every latched channel
    logic thermHot;   // thermal shutdown state
    logic uvLow;      // supply lockout state
  } guardCtl_t;

endpackage

// File: rtl/fault_guard_ctrl.sv
module fault_guard_ctrl
  import fault_guard_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int VDD_W  = 8,
  parameter int TRIP_T = 165,
  parameter int HYST_T = 10,
  parameter int UV_ON  = 45,
  parameter int UV_OFF = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic [VDD_W-1:0]  vddCode,
  input  logic              enReset,
  output guardCtl_t         ctl
);

  localparam int COOL_T = TRIP_T - HYST_T;
  localparam logic [TEMP_W-1:0] tripCode = TEMP_W'(TRIP_T);
  localparam logic [TEMP_W-1:0] coolCode = TEMP_W'(COOL_T);
  localparam logic [VDD_W-1:0]  onCode   = VDD_W'(UV_ON);
  localparam logic [VDD_W-1:0]  offCode  = VDD_W'(UV_OFF);

  logic enResetQ;
  logic thermHot;
  logic uvLow;

  // Previous level of enReset, for detecting its rising edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enResetQ <= 1'b0;
    else       enResetQ <= enReset;
  end

  // Thermal shutdown, with hysteresis and no latch.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thermHot <= 1'b0;
    end else if (!thermHot && (tempCode > tripCode)) begin
      thermHot <= 1'b1;
    end else if (thermHot && (tempCode < coolCode)) begin
      thermHot <= 1'b0;
    end
  end

  // Supply lockout: engaged out of reset, released once the supply is good.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uvLow <= 1'b1;
    end else if (uvLow && (vddCode >= onCode)) begin
      uvLow <= 1'b0;
    end else if (!uvLow && (vddCode < offCode)) begin
      uvLow <= 1'b1;
    end
  end

  always_comb begin
    ctl.clearAll = enReset & ~enResetQ;
    ctl.thermHot = thermHot;
    ctl.uvLow    = uvLow;
  end

endmodule

// File: rtl/fault_guard_dp.sv
module fault_guard_dp
  import fault_guard_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int FILT_CYC = 200
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] ocFlag,
  input  guardCtl_t      ctl,
  output logic [NCH-1:0] latched,
  output logic [NCH-1:0] chanOff,
  output logic           globalOff
);

  localparam int CNT_W = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
  localparam logic [CNT_W-1:0] lastCnt = CNT_W'(FILT_CYC - 1);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [CNT_W-1:0] persistCnt;
    logic             tripped;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        persistCnt <= '0;
        tripped    <= 1'b0;
      end else if (ctl.clearAll) begin
        persistCnt <= '0;
        tripped    <= 1'b0;
      end else if (ocFlag[ch] && !tripped) begin
        if (persistCnt == lastCnt) begin
          persistCnt <= '0;
          tripped    <= 1'b1;
        end else begin
          persistCnt <= persistCnt + 1'b1;
        end
      end else begin
        persistCnt <= '0;
      end
    end

    assign latched[ch] = tripped;
  end

  assign globalOff = ctl.thermHot | ctl.uvLow;
  assign chanOff   = latched | {NCH{globalOff}};

endmodule

// File: rtl/fault_guard.sv
module fault_guard
  import fault_guard_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int FILT_CYC = 200,
  parameter int TEMP_W   = 8,
  parameter int VDD_W    = 8,
  parameter int TRIP_T   = 165,
  parameter int HYST_T   = 10,
  parameter int UV_ON    = 45,
  parameter int UV_OFF   = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    ocFlag,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic [VDD_W-1:0]  vddCode,
  input  logic              enReset,
  output logic [NCH-1:0]    chanOff,
  output logic              globalOff,
  output logic [NCH-1:0]    faultVec
);

  guardCtl_t ctl;

  fault_guard_ctrl #(
    .TEMP_W(TEMP_W), .VDD_W(VDD_W), .TRIP_T(TRIP_T),
    .HYST_T(HYST_T), .UV_ON(UV_ON), .UV_OFF(UV_OFF)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .tempCode(tempCode),
    .vddCode(vddCode), .enReset(enReset), .ctl(ctl)
  );

  fault_guard_dp #(
    .NCH(NCH), .FILT_CYC(FILT_CYC)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ocFlag(ocFlag), .ctl(ctl),
    .latched(faultVec), .chanOff(chanOff), .globalOff(globalOff)
  );

endmodule

// File: rtl/fault_guard_chk.sv
module fault_guard_chk #(
  parameter int NCH    = 8,
  parameter int TEMP_W = 8,
  parameter int VDD_W  = 8,
  parameter int TRIP_T = 165,
  parameter int UV_OFF = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic [NCH-1:0]    ocFlag,
  input logic [TEMP_W-1:0] tempCode,
  input logic [VDD_W-1:0]  vddCode,
  input logic              enReset,
  input logic [NCH-1:0]    chanOff,
  input logic              globalOff,
  input logic [NCH-1:0]    faultVec
);

  // A latch is set only after its overcurrent bit was seen high.
  for (genvar ch = 0; ch < NCH; ch++) begin : g_trip
    assert_trip_needs_oc_R2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(faultVec[ch]) |-> $past(ocFlag[ch]));
  end

  // Latches never drop unless a reset edge was sampled.
  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(enReset) |=> ((faultVec & $past(faultVec)) == $past(faultVec)));

  // A rising enable/reset clears all latches.
  assert_clear_on_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enReset) |=> (faultVec == '0));

  assert_hot_shuts_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tempCode > TEMP_W'(TRIP_T)) |=> globalOff);

  assert_low_supply_shuts_R8: assert property (@(posedge clk) disable iff (!rstN)
    (vddCode < VDD_W'(UV_OFF)) |=> globalOff);

  assert_global_inhibit_R9: assert property (@(posedge clk) disable iff (!rstN)
    globalOff |-> (&chanOff));

  assert_latched_inhibit_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((faultVec & ~chanOff) == '0));

endmodule

bind fault_guard fault_guard_chk #(
  .NCH(NCH), .TEMP_W(TEMP_W), .VDD_W(VDD_W), .TRIP_T(TRIP_T), .UV_OFF(UV_OFF)
) u_chk (.*);

// File: tb/test_fault_guard.sv
module test_fault_guard;

  localparam int NCH    = 8;
  localparam int FILT   = 4;
  localparam int TRIP_T = 165;
  localparam int HYST_T = 10;
  localparam int UV_ON  = 45;
  localparam int UV_OFF = 40;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NCH-1:0] ocFlag = '0;
  logic [7:0]     tempCode = 8'd25;
  logic [7:0]     vddCode = 8'd50;
  logic           enReset = 1'b0;
  logic [NCH-1:0] chanOff;
  logic           globalOff;
  logic [NCH-1:0] faultVec;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  fault_guard #(
    .NCH(NCH), .FILT_CYC(FILT), .TEMP_W(8), .VDD_W(8),
    .TRIP_T(TRIP_T), .HYST_T(HYST_T), .UV_ON(UV_ON), .UV_OFF(UV_OFF)
  ) i_fault_guard (
    .clk(clk), .rstN(rstN), .ocFlag(ocFlag), .tempCode(tempCode),
    .vddCode(vddCode), .enReset(enReset), .chanOff(chanOff),
    .globalOff(globalOff), .faultVec(faultVec)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearFaults();
    enReset = 1'b1;
    step();
    enReset = 1'b0;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    // R1: reset state
    step();
    step();
    rstN = 1'b1;
    chk("R1 faultVec", 32'(faultVec), 0);
    chk("R1 globalOff", 32'(globalOff), 1);
    chk("R1 chanOff", 32'(chanOff), 32'hFF);
    step();
    chk("R8 release on good supply", 32'(globalOff), 0);
    chk("R9 chanOff clear", 32'(chanOff), 0);

    // R2: every channel, run lengths 1..FILT+1
    for (int ch = 0; ch < NCH; ch++) begin
      for (int n = 1; n <= FILT + 1; n++) begin
        ocFlag = NCH'(1) << ch;
        repeat (n) step();
        ocFlag = '0;
        chk($sformatf("R2 ch%0d run%0d faultVec", ch, n), 32'(faultVec),
            (n >= FILT) ? (32'd1 << ch) : 0);
        chk($sformatf("R9 ch%0d run%0d chanOff", ch, n), 32'(chanOff),
            (n >= FILT) ? (32'd1 << ch) : 0);
        clearFaults();
        chk("R5 cleared", 32'(faultVec), 0);
      end
    end

    // R3: broken runs must not add up
    ocFlag = 8'h04;
    repeat (FILT - 1) step();
    ocFlag = '0;
    step();
    ocFlag = 8'h04;
    repeat (FILT - 1) step();
    ocFlag = '0;
    step();
    chk("R3 restart after drop", 32'(faultVec), 0);

    // R4: independence and persistence
    ocFlag = 8'h42;
    repeat (FILT) step();
    ocFlag = '0;
    chk("R4 two channels", 32'(faultVec), 32'h42);
    repeat (20) step();
    chk("R4 persists", 32'(faultVec), 32'h42);
    chk("R9 chanOff latched", 32'(chanOff), 32'h42);
    clearFaults();

    // R5: edge clears; level held does not; persisting fault re-latches
    ocFlag = 8'h08;
    repeat (FILT) step();
    chk("R5 latched before clear", 32'(faultVec), 32'h08);
    enReset = 1'b1;
    step();
    chk("R5 edge clears", 32'(faultVec), 0);
    repeat (FILT - 1) step();
    chk("R5 not yet re-latched", 32'(faultVec), 0);
    step();
    chk("R5 re-latch with level held", 32'(faultVec), 32'h08);
    ocFlag = '0;
    enReset = 1'b0;
    step();
    clearFaults();

    // R6/R7 thermal, with channel 0 latched to test R9
    ocFlag = 8'h01;
    repeat (FILT) step();
    ocFlag = '0;
    for (int t = 160; t <= 170; t++) begin
      tempCode = 8'(t);
      step();
      chk($sformatf("R6 rising temp %0d", t), 32'(globalOff), (t > TRIP_T) ? 1 : 0);
    end
    chk("R9 hot inhibits all", 32'(chanOff), 32'hFF);
    for (int t = 170; t >= 150; t--) begin
      tempCode = 8'(t);
      step();
      chk($sformatf("R7 falling temp %0d", t), 32'(globalOff),
          (t >= TRIP_T - HYST_T) ? 1 : 0);
    end
    chk("R9 latch kept through thermal", 32'(faultVec), 32'h01);
    chk("R9 chanOff after cool", 32'(chanOff), 32'h01);
    tempCode = 8'd25;
    clearFaults();

    // R8 supply lockout with hysteresis
    for (int v = 50; v >= 35; v--) begin
      vddCode = 8'(v);
      step();
      chk($sformatf("R8 falling vdd %0d", v), 32'(globalOff), (v < UV_OFF) ? 1 : 0);
    end
    for (int v = 35; v <= 50; v++) begin
      vddCode = 8'(v);
      step();
      chk($sformatf("R8 rising vdd %0d", v), 32'(globalOff), (v < UV_ON) ? 1 : 0);
    end
    chk("R9 outputs back on", 32'(chanOff), 0);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule